// File: doc/BRIEF.md
# Sync Output Formatter

This block sits at the output of a video capture path and runs on the pixel clock. It rebuilds the horizontal sync as a pulse of programmable width: a one-cycle trigger marks the leading edge, and a down-counter holds the pulse for as many pixel clocks as the 8-bit width word gives. The vertical sync, display enable, field flag and the selected composite sync go through the same output stage. Each one gets its own polarity control and a single output register, so every output has the same one-clock latency.

A 2-bit select picks which of four candidate sync sources drives the composite-sync output. The choices are the raw sliced sync, the raw horizontal sync, a regenerated sync, and the sync sent to the clock-recovery loop. The field output uses a swap bit instead of a plain polarity bit. The swap bit decides whether a high output marks the odd field or the even field. The control words come from a register bank outside this block. Their intended power-up values are: width 32, every polarity bit 1, field swap 1, select 11.

Top module: `sync_out_formatter`

## Requirements
- R1: After a trigger cycle with a nonzero width W, `hsOut` is at its active level for exactly W consecutive samples. The first active sample is the cycle after the clock edge that captured the trigger.
- R2: A trigger while the width is 0 produces no active `hsOut`. If a pulse is already running, it ends and `hsOut` is inactive from the next cycle.
- R3: A trigger that arrives during a pulse restarts the count, so the pulse lasts W cycles from the new trigger.
- R4: The active level of `hsOut` is high when `hsPolHigh` is 1 and low when it is 0. When no pulse is running, `hsOut` equals the inverse of `hsPolHigh`.
- R5: `vsOut` equals `vsIn` when `vsPolHigh` is 1 and its inverse when it is 0. `deOut` follows `deIn` and `dePolHigh` by the same rule.
- R6: `fieldOdd` is 1 for the odd field. With `fieldPolSwap` at 0, `fieldOut` is high for the odd field. With `fieldPolSwap` at 1, `fieldOut` is high for the even field.
- R7: `sogSel` picks the composite-sync source: 00 `sogRawIn`, 01 `hsRawIn`, 10 `regenSyncIn`, 11 `pllSyncIn`.
- R8: The polarity control `sogPolHigh` acts on the selected source. A value of 1 passes it through and 0 inverts it.
- R9: All five outputs are registered. A change on any data or control input appears at the outputs only after the next rising clock edge, and in that same cycle for every output.
- R10: While `rstN` is low, all outputs are 0 and no pulse is pending. After reset is released, `hsOut` stays inactive until a trigger arrives.
- R11: The width is taken only at the trigger. Changing `hsDuration` during a running pulse does not change that pulse's length.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Pixel clock |
| rstN | input | 1 | Active-low synchronous reset |
| hsTrig | input | 1 | One-cycle leading-edge trigger for the horizontal pulse |
| hsDuration | input | 8 | Horizontal pulse width in pixel clocks |
| hsPolHigh | input | 1 | 1 = active-high `hsOut`, 0 = active-low |
| vsIn | input | 1 | Internal vertical sync, active high |
| vsPolHigh | input | 1 | Polarity of `vsOut` |
| deIn | input | 1 | Internal display enable, active high |
| dePolHigh | input | 1 | Polarity of `deOut` |
| fieldOdd | input | 1 | 1 = odd field |
| fieldPolSwap | input | 1 | 0 = high output is odd field, 1 = high output is even field |
| sogRawIn | input | 1 | Raw sliced composite sync |
| hsRawIn | input | 1 | Raw horizontal sync |
| regenSyncIn | input | 1 | Regenerated sync from the sync filter |
| pllSyncIn | input | 1 | Sync sent to the clock-recovery loop |
| sogSel | input | 2 | Composite-sync source select |
| sogPolHigh | input | 1 | Polarity of `sogOut` |
| hsOut | output | 1 | Regenerated horizontal sync |
| vsOut | output | 1 | Polarity-adjusted vertical sync |
| deOut | output | 1 | Polarity-adjusted display enable |
| fieldOut | output | 1 | Polarity-adjusted field flag |
| sogOut | output | 1 | Selected, polarity-adjusted composite sync |

## Verification
The hardest cases to reach are the ones where a trigger lands on a pulse that is already running: a restart with a nonzero width, and a cut-off with a width of 0. Width changes in the middle of a pulse are just as hard. The stimulus sets these up with scripted trigger sequences: a second trigger placed a few cycles into a pulse, and width changes timed to a chosen cycle. Each expected active span is worked out from the trigger positions. Every width from 0 to 255 is swept with alternating polarity, and all 128 combinations of source select, polarity and source levels are driven.

// File: rtl/sofmt_pkg.sv
package sofmt_pkg;

  // Strobes from the width control to the output datapath
  typedef struct packed {
    logic hsPulse;  // regenerated horizontal pulse, active high, this cycle
    logic busy;     // count still running after this cycle
  } hsStrobe_t;

  typedef enum logic [1:0] {
    SOG_SLICED = 2'b00,
    SOG_HSRAW  = 2'b01,
    SOG_REGEN  = 2'b10,
    SOG_LOOP   = 2'b11
  } sogSel_e;

endpackage

// File: rtl/sofmt_hs_ctrl.sv
module sofmt_hs_ctrl
  import sofmt_pkg::*;
#(
  parameter int DUR_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             hsTrig,
  input  logic [DUR_W-1:0] hsDuration,
  output hsStrobe_t        strb
);

  logic [DUR_W-1:0] remain;   // cycles still to run after the current one
  logic             durNonZero;

  assign durNonZero = |hsDuration;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      remain <= '0;
    end else if (hsTrig) begin
      remain <= durNonZero ? hsDuration - DUR_W'(1) : '0;
    end else if (remain != '0) begin
      remain <= remain - DUR_W'(1);
    end
  end

  always_comb begin
    strb.hsPulse = hsTrig ? durNonZero : (remain != '0);
    strb.busy    = (remain != '0);
  end

  AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rstN)
    (!strb.busy && !hsTrig) |=> !strb.busy);                          // R1
  AST_ZERO_WIDTH_CLEARS: assert property (@(posedge clk) disable iff (!rstN)
    (hsTrig && !durNonZero) |=> !strb.busy);                          // R2
  AST_RESTART_LOAD: assert property (@(posedge clk) disable iff (!rstN)
    (hsTrig && durNonZero) |=> (strb.busy == ($past(hsDuration) > DUR_W'(1)))); // R3
  AST_COUNT_IGNORES_WIDTH: assert property (@(posedge clk) disable iff (!rstN)
    (strb.busy && !hsTrig) |=> (remain == $past(remain) - DUR_W'(1))); // R11

endmodule

// File: rtl/sofmt_out_dpath.sv
module sofmt_out_dpath
  import sofmt_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  hsStrobe_t strb,
  input  logic      hsPolHigh,
  input  logic      vsIn,
  input  logic      vsPolHigh,
  input  logic      deIn,
  input  logic      dePolHigh,
  input  logic      fieldOdd,
  input  logic      fieldPolSwap,
  input  logic      sogRawIn,
  input  logic      hsRawIn,
  input  logic      regenSyncIn,
  input  logic      pllSyncIn,
  input  logic [1:0] sogSel,
  input  logic      sogPolHigh,
  output logic      hsOut,
  output logic      vsOut,
  output logic      deOut,
  output logic      fieldOut,
  output logic      sogOut
);

  localparam int N_POL = 4;   // hs, vs, de, sog share the plain polarity rule

  logic             sogPick;
  logic [N_POL-1:0] polIn;
  logic [N_POL-1:0] polHigh;
  logic [N_POL-1:0] polReg;
  logic             fieldReg;

  always_comb begin
    unique case (sogSel_e'(sogSel))
      SOG_SLICED: sogPick = sogRawIn;
      SOG_HSRAW:  sogPick = hsRawIn;
      SOG_REGEN:  sogPick = regenSyncIn;
      default:    sogPick = pllSyncIn;
    endcase
  end

  assign polIn   = {sogPick, deIn, vsIn, strb.hsPulse};
  assign polHigh = {sogPolHigh, dePolHigh, vsPolHigh, hsPolHigh};

  for (genvar g = 0; g < N_POL; g++) begin : gPol
    always_ff @(posedge clk) begin
      if (!rstN) polReg[g] <= 1'b0;
      else       polReg[g] <= polHigh[g] ? polIn[g] : ~polIn[g];
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) fieldReg <= 1'b0;
    else       fieldReg <= fieldPolSwap ? ~fieldOdd : fieldOdd;
  end

  assign hsOut    = polReg[0];
  assign vsOut    = polReg[1];
  assign deOut    = polReg[2];
  assign sogOut   = polReg[3];
  assign fieldOut = fieldReg;

  AST_HS_IDLE_LEVEL: assert property (@(posedge clk) disable iff (!rstN)
    (!strb.hsPulse && !strb.busy) |=> (hsOut == !$past(hsPolHigh)));   // R4
  AST_VS_LEVEL: assert property (@(posedge clk) disable iff (!rstN)
    vsPolHigh |=> (vsOut == $past(vsIn)));                            // R5
  AST_FIELD_SWAP: assert property (@(posedge clk) disable iff (!rstN)
    fieldPolSwap |=> (fieldOut != $past(fieldOdd)));                  // R6
  AST_SOG_LOOP_SRC: assert property (@(posedge clk) disable iff (!rstN)
    (sogSel == 2'b11 && sogPolHigh) |=> (sogOut == $past(pllSyncIn))); // R7
  AST_SOG_INVERT: assert property (@(posedge clk) disable iff (!rstN)
    (sogSel == 2'b01 && !sogPolHigh) |=> (sogOut == !$past(hsRawIn))); // R8

endmodule

// File: rtl/sync_out_formatter.sv
module sync_out_formatter
  import sofmt_pkg::*;
#(
  parameter int DUR_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             hsTrig,
  input  logic [DUR_W-1:0] hsDuration,
  input  logic             hsPolHigh,
  input  logic             vsIn,
  input  logic             vsPolHigh,
  input  logic             deIn,
  input  logic             dePolHigh,
  input  logic             fieldOdd,
  input  logic             fieldPolSwap,
  input  logic             sogRawIn,
  input  logic             hsRawIn,
  input  logic             regenSyncIn,
  input  logic             pllSyncIn,
  input  logic [1:0]       sogSel,
  input  logic             sogPolHigh,
  output logic             hsOut,
  output logic             vsOut,
  output logic             deOut,
  output logic             fieldOut,
  output logic             sogOut
);

  hsStrobe_t strb;

  sofmt_hs_ctrl #(.DUR_W(DUR_W)) i_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .hsTrig     (hsTrig),
    .hsDuration (hsDuration),
    .strb       (strb)
  );

  sofmt_out_dpath i_dpath (
    .clk          (clk),
    .rstN         (rstN),
    .strb         (strb),
    .hsPolHigh    (hsPolHigh),
    .vsIn         (vsIn),
    .vsPolHigh    (vsPolHigh),
    .deIn         (deIn),
    .dePolHigh    (dePolHigh),
    .fieldOdd     (fieldOdd),
    .fieldPolSwap (fieldPolSwap),
    .sogRawIn     (sogRawIn),
    .hsRawIn      (hsRawIn),
    .regenSyncIn  (regenSyncIn),
    .pllSyncIn    (pllSyncIn),
    .sogSel       (sogSel),
    .sogPolHigh   (sogPolHigh),
    .hsOut        (hsOut),
    .vsOut        (vsOut),
    .deOut        (deOut),
    .fieldOut     (fieldOut),
    .sogOut       (sogOut)
  );

  AST_RESET_QUIET: assert property (@(posedge clk)
    !rstN |=> (!hsOut && !vsOut && !deOut && !fieldOut && !sogOut)); // R10

endmodule

// File: tb/test_sync_out_formatter.sv
module test_sync_out_formatter;

  logic       clk = 1'b0;
  logic       rstN;
  logic       hsTrig;
  logic [7:0] hsDuration;
  logic       hsPolHigh, vsIn, vsPolHigh, deIn, dePolHigh;
  logic       fieldOdd, fieldPolSwap;
  logic       sogRawIn, hsRawIn, regenSyncIn, pllSyncIn;
  logic [1:0] sogSel;
  logic       sogPolHigh;
  logic       hsOut, vsOut, deOut, fieldOut, sogOut;

  int nChecks = 0;
  int nFails  = 0;
  bit done    = 1'b0;

  always #10 clk = ~clk;   // 50 MHz

  sync_out_formatter i_sync_out_formatter (
    .clk(clk), .rstN(rstN), .hsTrig(hsTrig), .hsDuration(hsDuration),
    .hsPolHigh(hsPolHigh), .vsIn(vsIn), .vsPolHigh(vsPolHigh),
    .deIn(deIn), .dePolHigh(dePolHigh), .fieldOdd(fieldOdd),
    .fieldPolSwap(fieldPolSwap), .sogRawIn(sogRawIn), .hsRawIn(hsRawIn),
    .regenSyncIn(regenSyncIn), .pllSyncIn(pllSyncIn), .sogSel(sogSel),
    .sogPolHigh(sogPolHigh), .hsOut(hsOut), .vsOut(vsOut), .deOut(deOut),
    .fieldOut(fieldOut), .sogOut(sogOut)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  endtask

  // One trigger of width dur; count active samples and where they sit (R1, R2, R4)
  task automatic pulseRun(input int dur, input bit pol);
    int actN = 0;
    bit shapeOk = 1'b1;
    hsPolHigh  = pol;
    hsDuration = 8'(dur);
    hsTrig     = 1'b1;
    for (int k = 0; k < dur + 3; k++) begin
      @(negedge clk);
      hsTrig = 1'b0;
      if (hsOut == pol) actN++;
      if ((hsOut == pol) != (k < dur)) shapeOk = 1'b0;
    end
    chk(shapeOk && actN == dur, dur == 0 ? "R2" : (pol ? "R1" : "R4"), actN, dur);
  endtask

  // Scripted trigger sequence: first trigger at 0, optional second at bAt,
  // width switches from durA to durB at swAt; expect active on samples 0..expN-1
  task automatic seqRun(input int bAt, input int swAt, input int durA,
                        input int durB, input int expN, input string req);
    int actN = 0;
    bit shapeOk = 1'b1;
    hsPolHigh = 1'b1;
    for (int i = 0; i < 40; i++) begin
      hsTrig     = (i == 0) || (i == bAt);
      hsDuration = 8'((i >= swAt) ? durB : durA);
      @(negedge clk);
      if (hsOut) actN++;
      if (hsOut != (i < expN)) shapeOk = 1'b0;
    end
    hsTrig = 1'b0;
    chk(shapeOk && actN == expN, req, actN, expN);
  endtask

  initial begin
    rstN = 1'b0; hsTrig = 1'b0; hsDuration = 8'd32; hsPolHigh = 1'b1;
    vsIn = 1'b1; vsPolHigh = 1'b1; deIn = 1'b1; dePolHigh = 1'b1;
    fieldOdd = 1'b0; fieldPolSwap = 1'b1;
    sogRawIn = 1'b1; hsRawIn = 1'b1; regenSyncIn = 1'b1; pllSyncIn = 1'b1;
    sogSel = 2'b11; sogPolHigh = 1'b1;
    repeat (3) @(negedge clk);
    // R10: reset holds every output low
    chk({hsOut, vsOut, deOut, fieldOut, sogOut} == 5'b0, "R10",
        {hsOut, vsOut, deOut, fieldOut, sogOut}, 0);
    hsTrig = 1'b1;                       // trigger during reset leaves nothing pending
    @(negedge clk);
    hsTrig = 1'b0; rstN = 1'b1;
    repeat (2) @(negedge clk);
    chk(hsOut == 1'b0, "R10", hsOut, 0); // idle, active-high -> low

    // R1/R2/R4: every width, alternating polarity
    for (int d = 0; d < 256; d++) pulseRun(d, d[0] == 1'b0);

    // R3: retrigger at 5 with width 10 -> 15 active samples
    seqRun(5, 99, 10, 10, 15, "R3");
    // R2: zero-width trigger at 3 cuts the pulse after 3 samples
    seqRun(3, 3, 10, 0, 3, "R2");
    // R11: width raised mid-pulse, pulse stays 6 long
    seqRun(-1, 1, 6, 50, 6, "R11");
    // R11: width lowered mid-pulse, pulse stays 20 long
    seqRun(-1, 2, 20, 1, 20, "R11");

    // R5..R8: exhaustive over select, polarity and levels
    for (int c = 0; c < 128; c++) begin
      logic [6:0] v = 7'(c);
      logic       srcPick;
      vsIn = v[0]; vsPolHigh = v[1]; deIn = v[2]; dePolHigh = v[3];
      fieldOdd = v[4]; fieldPolSwap = v[5]; hsPolHigh = v[6];
      sogSel = v[1:0]; sogPolHigh = v[2];
      {pllSyncIn, regenSyncIn, hsRawIn, sogRawIn} = v[6:3];
      srcPick = v[3 + v[1:0]];
      @(negedge clk);
      chk(vsOut == (vsPolHigh ? vsIn : !vsIn), "R5", vsOut, vsPolHigh ? vsIn : !vsIn);
      chk(deOut == (dePolHigh ? deIn : !deIn), "R5", deOut, dePolHigh ? deIn : !deIn);
      chk(fieldOut == (fieldOdd ^ fieldPolSwap), "R6", fieldOut, fieldOdd ^ fieldPolSwap);
      if (sogPolHigh)
        chk(sogOut == srcPick, "R7", sogOut, srcPick);
      else
        chk(sogOut == !srcPick, "R8", sogOut, !srcPick);
      chk(hsOut == !hsPolHigh, "R4", hsOut, !hsPolHigh);
    end

    // R9: an input change is not visible before the edge, then all move together
    vsIn = 1'b0; vsPolHigh = 1'b1; deIn = 1'b0; dePolHigh = 1'b1;
    fieldOdd = 1'b1; fieldPolSwap = 1'b0; sogSel = 2'b00; sogRawIn = 1'b0; sogPolHigh = 1'b1;
    @(negedge clk);
    vsIn = 1'b1; deIn = 1'b1; fieldOdd = 1'b0; sogRawIn = 1'b1;
    #5;
    chk({vsOut, deOut, fieldOut, sogOut} == 4'b0010, "R9",
        {vsOut, deOut, fieldOut, sogOut}, 4'b0010);
    @(negedge clk);
    chk({vsOut, deOut, fieldOut, sogOut} == 4'b1101, "R9",
        {vsOut, deOut, fieldOut, sogOut}, 4'b1101);

    done = 1'b1;
    summary();
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      chk(1'b0, "watchdog", 0, 1);
      summary();
    end
  end

endmodule